// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block turns pairs of parallel audio samples into a three-wire serial stream: a bit clock, a frame (left/right) clock and one data line. A left/right sample pair enters through a valid/ready handshake into a single holding slot. At the start of every frame, the pair in that slot becomes the pair being shifted out. If the slot is empty at that moment, a frame of zeros is sent and an underrun pulse is raised.

Timing comes from a `half_tick` enable supplied by a separate clock generator. Each pulse marks one half period of the bit clock. The pulse that opens a bit slot launches the new data bit. The pulse after it is the capture half.

Static configuration inputs select the following:
- the placement of a sample within its half-frame: standard I2S delay, left-aligned or right-aligned;
- the sample width;
- the bit order;
- the frame-clock and bit-clock polarities;
- a PCM framing mode, in which the frame clock is a one-slot pulse;
- the half-frame length in bit slots.

The configuration is expected to change only while `tx_en` is low.

Top module: `audtx_serializer`

## Requirements
- R1: `cfg_align` selects where a sample sits in its half-frame. 0 puts the first sent bit in slot 1 (standard I2S, one slot after the frame-clock edge). 1 puts it in slot 0 (left-aligned). 2 puts the last sent bit in slot `cfg_half_len`-1 (right-aligned). 3 behaves as 1.
- R2: The sample width is `cfg_width_m1`+1 bits, capped at DATA_W. Widths 8, 16, 20 and 24 work. Every slot outside the sample's bits drives `sd_o` low.
- R3: `cfg_lsb_first`=0 sends bit width-1 first. `cfg_lsb_first`=1 sends bit 0 first.
- R4: Outside PCM mode, `lrck_o` is 0 during the left half (channel 0) and 1 during the right half, XORed with `cfg_frame_inv`. A frame starts with the left half.
- R5: `sclk_o` is the bit-clock phase XORed with `cfg_bclk_inv`. With `cfg_bclk_inv`=0, data changes on the falling edge of `sclk_o`. With 1, data changes on the rising edge. Each `half_tick` toggles the phase while enabled.
- R6: With `cfg_pcm`=1, `lrck_o` is 1 (XOR `cfg_frame_inv`) only during slot 0 of the left half. It is 0 (XOR `cfg_frame_inv`) elsewhere. Data placement is unchanged.
- R7: While `tx_en` is 0, the following hold: `sd_o`=0, `underrun_o`=0, `lrck_o`=`cfg_frame_inv`, `sclk_o`=1 XOR `cfg_bclk_inv`, and `half_tick` is ignored. The first `half_tick` after enabling launches slot 0 of a new frame.
- R8: When a frame starts with no pair held, that frame sends zeros. `underrun_o` is high for exactly one clock, in the cycle the frame's first slot is launched.
- R9: `in_ready` is 1 exactly when the holding slot is empty. A pair is taken on `in_valid && in_ready`. The held pair moves out of the slot at each frame start.
- R10: After reset, the outputs are `sd_o`=0, `underrun_o`=0, `lrck_o`=0 and `in_ready`=1, and the bit-clock phase is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| half_tick | input | 1 | One pulse per bit-clock half period |
| cfg_align | input | 2 | Sample placement mode |
| cfg_width_m1 | input | 5 | Sample width minus one |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_frame_inv | input | 1 | Frame clock inversion |
| cfg_bclk_inv | input | 1 | Bit clock inversion |
| cfg_pcm | input | 1 | PCM pulse framing select |
| cfg_half_len | input | SLOT_W | Bit slots per half-frame (at least 2) |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Holding slot empty |
| in_left | input | DATA_W | Left sample |
| in_right | input | DATA_W | Right sample |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-clock pulse when a frame starts empty |

## Verification
A slot counter that drifts by one shows up as a misplaced data bit within that same slot. A wrong channel bit flips `lrck_o` for a whole half-frame. A holding slot that is lost or duplicated changes `in_ready` one clock after the handshake, and it corrupts or repeats the next frame's first sent bit. A missed underrun is visible in the single launch cycle of the frame start. Because the reference model is compared on every clock, each of these faults is reported at most one bit slot after it occurs.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
   typedef enum logic [1:0] {
      ALIGN_I2S   = 2'd0,
      ALIGN_LEFT  = 2'd1,
      ALIGN_RIGHT = 2'd2,
      ALIGN_RSVD  = 2'd3
   } align_e;
endpackage

// File: rtl/audtx_slot_timer.sv
module audtx_slot_timer #(
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              half_tick,
   input  logic [SLOT_W-1:0] cfg_half_len,
   output logic              phase,
   output logic              launch,
   output logic [SLOT_W-1:0] nxt_slot,
   output logic              nxt_chan,
   output logic              frame_start
);
   logic [SLOT_W-1:0] slot_q;
   logic              chan_q;
   logic              started_q;
   logic [SLOT_W:0]   slot_inc;

   assign slot_inc = {1'b0, slot_q} + {{SLOT_W{1'b0}}, 1'b1};

   always_comb begin
      if (!started_q) begin
         nxt_slot = '0;
         nxt_chan = 1'b0;
      end else if (slot_inc >= {1'b0, cfg_half_len}) begin
         nxt_slot = '0;
         nxt_chan = ~chan_q;
      end else begin
         nxt_slot = slot_inc[SLOT_W-1:0];
         nxt_chan = chan_q;
      end
   end

   assign launch      = tx_en && half_tick && phase;
   assign frame_start = launch && (nxt_slot == '0) && !nxt_chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= 1'b1;
         slot_q    <= '0;
         chan_q    <= 1'b0;
         started_q <= 1'b0;
      end else if (!tx_en) begin
         phase     <= 1'b1;
         slot_q    <= '0;
         chan_q    <= 1'b0;
         started_q <= 1'b0;
      end else if (half_tick) begin
         phase <= ~phase;
         if (phase) begin
            slot_q    <= nxt_slot;
            chan_q    <= nxt_chan;
            started_q <= 1'b1;
         end
      end
   end

   // R5
   sclk_phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(phase) && $past(tx_en)) |-> $past(half_tick));
endmodule

// File: rtl/audtx_sample_buf.sv
module audtx_sample_buf #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   output logic              in_ready,
   input  logic              take,
   output logic [DATA_W-1:0] sel_left,
   output logic [DATA_W-1:0] sel_right,
   output logic              starve
);
   logic [DATA_W-1:0] pend_l, pend_r, cur_l, cur_r;
   logic              full_q;

   assign in_ready  = !full_q;
   assign starve    = take && !full_q;
   assign sel_left  = take ? (full_q ? pend_l : '0) : cur_l;
   assign sel_right = take ? (full_q ? pend_r : '0) : cur_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         pend_l <= '0;
         pend_r <= '0;
         cur_l  <= '0;
         cur_r  <= '0;
      end else begin
         if (take) begin
            cur_l <= sel_left;
            cur_r <= sel_right;
            if (full_q) full_q <= 1'b0;
         end
         if (in_valid && !full_q) begin
            pend_l <= in_left;
            pend_r <= in_right;
            full_q <= 1'b1;
         end
      end
   end

   // R9
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid));
endmodule

// File: rtl/audtx_bit_pick.sv
module audtx_bit_pick
   import audtx_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 6
) (
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   input  logic              chan,
   input  logic [SLOT_W-1:0] slot,
   input  logic [1:0]        cfg_align,
   input  logic [4:0]        cfg_width_m1,
   input  logic              cfg_lsb_first,
   input  logic [SLOT_W-1:0] cfg_half_len,
   output logic              bit_o
);
   logic [DATA_W-1:0] smp;
   int width_i, first_i, pos_i, idx_i;

   assign smp = chan ? smp_right : smp_left;

   always_comb begin
      width_i = int'(cfg_width_m1) + 1;
      if (width_i > DATA_W) width_i = DATA_W;
      case (align_e'(cfg_align))
         ALIGN_I2S:   first_i = 1;
         ALIGN_RIGHT: first_i = int'(cfg_half_len) - width_i;
         default:     first_i = 0;
      endcase
      pos_i = int'(slot) - first_i;
      idx_i = cfg_lsb_first ? pos_i : (width_i - 1 - pos_i);
      bit_o = 1'b0;
      if (pos_i >= 0 && pos_i < width_i) begin
         for (int i = 0; i < DATA_W; i++) begin
            if (i == idx_i) bit_o = smp[i];
         end
      end
   end
endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer #(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              half_tick,
   input  logic [1:0]        cfg_align,
   input  logic [4:0]        cfg_width_m1,
   input  logic              cfg_lsb_first,
   input  logic              cfg_frame_inv,
   input  logic              cfg_bclk_inv,
   input  logic              cfg_pcm,
   input  logic [SLOT_W-1:0] cfg_half_len,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   output logic              sclk_o,
   output logic              lrck_o,
   output logic              sd_o,
   output logic              underrun_o
);
   initial begin
      assert (DATA_W >= 8 && DATA_W <= 32) else $error("DATA_W out of range");
      assert (SLOT_W >= 2 && SLOT_W <= 8) else $error("SLOT_W out of range");
   end

   logic              phase, launch, nxt_chan, frame_start, starve, bit_w;
   logic [SLOT_W-1:0] nxt_slot;
   logic [DATA_W-1:0] sel_left, sel_right;

   audtx_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .half_tick(half_tick),
      .cfg_half_len(cfg_half_len), .phase(phase), .launch(launch),
      .nxt_slot(nxt_slot), .nxt_chan(nxt_chan), .frame_start(frame_start));

   audtx_sample_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
      .in_right(in_right), .in_ready(in_ready), .take(frame_start),
      .sel_left(sel_left), .sel_right(sel_right), .starve(starve));

   audtx_bit_pick #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_pick (
      .smp_left(sel_left), .smp_right(sel_right), .chan(nxt_chan),
      .slot(nxt_slot), .cfg_align(cfg_align), .cfg_width_m1(cfg_width_m1),
      .cfg_lsb_first(cfg_lsb_first), .cfg_half_len(cfg_half_len),
      .bit_o(bit_w));

   assign sclk_o = phase ^ cfg_bclk_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_o       <= 1'b0;
         lrck_o     <= 1'b0;
         underrun_o <= 1'b0;
      end else if (!tx_en) begin
         sd_o       <= 1'b0;
         lrck_o     <= cfg_frame_inv;
         underrun_o <= 1'b0;
      end else begin
         underrun_o <= 1'b0;
         if (launch) begin
            sd_o       <= bit_w;
            underrun_o <= starve;
            if (cfg_pcm) lrck_o <= ((nxt_slot == '0) && !nxt_chan) ^ cfg_frame_inv;
            else         lrck_o <= nxt_chan ^ cfg_frame_inv;
         end
      end
   end

   // R8
   underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> !sd_o);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!sd_o && !underrun_o));
   // R8
   underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |=> !underrun_o);
endmodule

// File: tb/audtx_serializer_tb.sv
module audtx_serializer_tb;
   localparam int DW = 24;
   localparam int SW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, half_tick = 1'b0;
   logic [1:0] cfg_align = 2'd0;
   logic [4:0] cfg_width_m1 = 5'd15;
   logic cfg_lsb_first = 1'b0, cfg_frame_inv = 1'b0, cfg_bclk_inv = 1'b0, cfg_pcm = 1'b0;
   logic [SW-1:0] cfg_half_len = 6'd32;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_left = '0, in_right = '0;
   logic in_ready, sclk_o, lrck_o, sd_o, underrun_o;

   always #2.5 clk = ~clk;

   audtx_serializer #(.DATA_W(DW), .SLOT_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .half_tick(half_tick),
      .cfg_align(cfg_align), .cfg_width_m1(cfg_width_m1),
      .cfg_lsb_first(cfg_lsb_first), .cfg_frame_inv(cfg_frame_inv),
      .cfg_bclk_inv(cfg_bclk_inv), .cfg_pcm(cfg_pcm), .cfg_half_len(cfg_half_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
      .in_right(in_right), .sclk_o(sclk_o), .lrck_o(lrck_o), .sd_o(sd_o),
      .underrun_o(underrun_o));

   int vectors = 0, fails = 0;
   string tag = "R10";
   bit feed_on = 1'b0;
   bit done = 1'b0;

   // reference model state
   logic [2*DW-1:0] q[$];
   logic [DW-1:0] m_l = '0, m_r = '0;
   int  m_slot = 0, m_ch = 0;
   bit  m_started = 0, m_phase = 1, m_sd = 0, m_lr = 0, m_ur = 0, m_acc = 0;

   function automatic bit ref_bit(logic [DW-1:0] s, int slot);
      int w, first, k;
      w = int'(cfg_width_m1) + 1;
      if (w > DW) w = DW;
      if (cfg_align == 2'd0) first = 1;
      else if (cfg_align == 2'd2) first = int'(cfg_half_len) - w;
      else first = 0;
      k = slot - first;
      if (k < 0 || k >= w) return 1'b0;
      if (cfg_lsb_first) return s[k];
      return s[w-1-k];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         m_l = '0; m_r = '0; m_slot = 0; m_ch = 0;
         m_started = 0; m_phase = 1; m_sd = 0; m_lr = 0; m_ur = 0; m_acc = 0;
      end else begin
         m_acc = in_valid && (q.size() == 0);
         m_ur = 0;
         if (!tx_en) begin
            m_started = 0; m_phase = 1; m_sd = 0; m_lr = cfg_frame_inv;
         end else if (half_tick) begin
            if (m_phase) begin
               if (!m_started) begin m_slot = 0; m_ch = 0; m_started = 1; end
               else begin
                  m_slot++;
                  if (m_slot >= int'(cfg_half_len)) begin m_slot = 0; m_ch ^= 1; end
               end
               if (m_slot == 0 && m_ch == 0) begin
                  if (q.size() > 0) begin
                     {m_l, m_r} = q.pop_front();
                  end else begin
                     m_l = '0; m_r = '0; m_ur = 1;
                  end
               end
               m_sd = ref_bit(m_ch ? m_r : m_l, m_slot);
               if (cfg_pcm) m_lr = (m_slot == 0 && m_ch == 0) ^ cfg_frame_inv;
               else m_lr = m_ch[0] ^ cfg_frame_inv;
               m_phase = 0;
            end else begin
               m_phase = 1;
            end
         end
         if (m_acc) q.push_back({in_left, in_right});
      end
   end

   task automatic check1(string name, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
      end
   endtask

   int tick_cnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         check1("sd_o", sd_o, m_sd);
         check1("lrck_o", lrck_o, m_lr);
         check1("sclk_o", sclk_o, m_phase ^ cfg_bclk_inv);
         check1("underrun_o", underrun_o, m_ur);
         check1("in_ready", in_ready, q.size() == 0);
         if (m_acc || !in_valid) begin
            in_valid <= feed_on;
            in_left  <= DW'($urandom);
            in_right <= DW'($urandom);
         end
      end
      tick_cnt++;
      half_tick <= (tick_cnt % 2 == 0);
   end

   task automatic run_cfg(string t, logic [1:0] al, logic [4:0] wm1, logic lsb,
                          logic finv, logic binv, logic pcm, int half, int frames);
      @(negedge clk);
      tx_en = 1'b0;
      repeat (3) @(negedge clk);
      tag = t;
      cfg_align = al; cfg_width_m1 = wm1; cfg_lsb_first = lsb;
      cfg_frame_inv = finv; cfg_bclk_inv = binv; cfg_pcm = pcm;
      cfg_half_len = SW'(half);
      repeat (2) @(negedge clk);
      tx_en = 1'b1;
      feed_on = 1'b1;
      repeat (frames * 8 * half) @(negedge clk);
      feed_on = 1'b0;
      repeat (3 * 8 * half) @(negedge clk);
      feed_on = 1'b1;
      repeat (2 * 8 * half) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state checked explicitly
      tag = "R10";
      check1("sd_o reset", sd_o, 1'b0);
      check1("underrun reset", underrun_o, 1'b0);
      check1("in_ready reset", in_ready, 1'b1);
      check1("sclk reset", sclk_o, 1'b1);
      run_cfg("R1 R2 R9 i2s16",   2'd0, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0, 32, 3);
      run_cfg("R1 R2 R8 left24",  2'd1, 5'd23, 1'b0, 1'b0, 1'b0, 1'b0, 32, 2);
      run_cfg("R1 R3 right20",    2'd2, 5'd19, 1'b1, 1'b0, 1'b0, 1'b0, 24, 2);
      run_cfg("R4 R5 R6 pcm8",    2'd0, 5'd7,  1'b0, 1'b1, 1'b1, 1'b1, 16, 2);
      run_cfg("R1 R2 R3 rsvd8",   2'd3, 5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 12, 2);
      // R7 drop enable mid-frame, check idle, then restart
      tag = "R7";
      @(negedge clk);
      tx_en = 1'b1;
      repeat (50) @(negedge clk);
      tx_en = 1'b0;
      repeat (20) @(negedge clk);
      check1("idle sd", sd_o, 1'b0);
      check1("idle lrck", lrck_o, cfg_frame_inv);
      tx_en = 1'b1;
      repeat (300) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule